// File: doc/BRIEF.md
# Multichannel PCM/TDM Serial Audio Receiver

This block captures serial audio that arrives on three wires: an externally driven bit clock, a frame sync and a data line. All three are brought into the system clock domain through flop synchronizers. Bit clock edges are found by comparing successive synchronized values. On every rising bit clock edge the block samples the frame sync and the data bit. The transmitter changes both lines on the falling edge, so they are stable when the receiver samples them.

A frame is a run of fixed 32-bit slots, one per channel. Channel 0 is anchored to the frame sync edge of a selectable polarity. A bit offset moves the first data bit later relative to that edge: a value of 1 gives the classic two-channel stereo format, and 0 gives the left-justified and TDM formats. Inside each slot the sample occupies either the leading or the trailing bit-depth bits, and it can be sent MSB first or LSB first. When a slot ends, the sample comes out sign-extended to 32 bits together with its channel index and a one-cycle valid strobe.

The block tracks the expected frame length. A sync edge that arrives anywhere else raises a one-cycle error pulse, and the slot counting restarts from that edge.

Top module: `pcm_tdm_rx`

## Requirements
- R1: While reset is held and after it is released, `sampleValid` and `syncErr` stay low until serial data is received.
- R2: Channel 0 starts at the falling frame sync edge when `cfgSyncFall` is 1 and at the rising edge when it is 0. Edges of the other polarity do not align the frame.
- R3: The first data bit of channel 0 is taken `cfgOffset` bit clocks (0 to 31) after the sync edge bit. A data bit that falls past the end of the frame wraps into the next sync edge bit time.
- R4: A frame holds `cfgChanCount` (1 to 8) slots of 32 bit clocks each. Samples carry channel index 0 to `cfgChanCount`-1 in slot order.
- R5: The sample width is `cfgBitDepth` (1 to 32; 0 is treated as 32). With `cfgRightJust`=0 the sample is the first bit-depth bits of the slot; with 1 it is the last bit-depth bits. All other bits are ignored.
- R6: With `cfgLsbFirst`=0 the first sample bit received is the MSB; with 1 it is the LSB.
- R7: Each complete slot yields exactly one `sampleValid` pulse, one system clock long, with the sample sign-extended to 32 bits.
- R8: Nothing is emitted before the first active sync edge. A slot whose first bit was not received in the current alignment is dropped.
- R9: An active sync edge that does not fall on the frame boundary gives a one-cycle `syncErr` pulse and restarts counting at channel 0. Edges on the boundary never raise `syncErr`.
- R10: The sync and data lines are sampled on rising bit clock edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bclkIn | input | 1 | External bit clock |
| fsyncIn | input | 1 | External frame sync |
| sdIn | input | 1 | Serial data |
| cfgSyncFall | input | 1 | 1: channel 0 at falling sync edge, 0: rising |
| cfgChanCount | input | 4 | Slots per frame, 1 to 8 |
| cfgBitDepth | input | 6 | Sample width, 1 to 32 (0 means 32) |
| cfgOffset | input | 5 | Bit clocks from sync edge to first data bit |
| cfgRightJust | input | 1 | 1: sample at the end of the slot |
| cfgLsbFirst | input | 1 | 1: LSB received first |
| sampleData | output | 32 | Sign-extended received sample |
| sampleChan | output | 3 | Channel index of sampleData |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| syncErr | output | 1 | One-cycle pulse on a misplaced sync edge |

## Verification
The offset-1 stereo case is the one most likely to expose a fault. There the last bit of the final slot lands on the next frame's sync edge bit. A receiver that does not wrap the data position either loses the final channel or shifts every sample by one bit. Right-justified and short-depth cases fill the unused slot bits with ones, so a window placed at the wrong end of the slot, or a sign extension taken from the wrong bit, gives visibly wrong values. The truncated-frame case checks four things: the error pulse fires once, the partial slot is dropped rather than emitted as garbage, following frames decode cleanly, and well-timed edges never flag an error. The falling-polarity and LSB-first runs catch a receiver that aligns to the wrong edge or reverses the bit order.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  // Per-bit strobes from control to datapath
  typedef struct packed {
    logic shift;  // current bit lies inside the sample window
    logic emit;   // current bit closes a complete slot
    logic sdBit;  // data bit sampled at this rising bit clock
  } rxStrobe_t;
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
  import pcm_rx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int MAX_CH = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              bclkS,
  input  logic                              fsS,
  input  logic                              sdS,
  input  logic                              cfgSyncFall,
  input  logic [$clog2(MAX_CH+1)-1:0]       cfgChanCount,
  input  logic [$clog2(SLOT_W+1)-1:0]       cfgBitDepth,
  input  logic [$clog2(SLOT_W)-1:0]         cfgOffset,
  input  logic                              cfgRightJust,
  output rxStrobe_t                         strobe,
  output logic [$clog2(MAX_CH)-1:0]         slotIdx,
  output logic [$clog2(SLOT_W+1)-1:0]       depthEff,
  output logic                              syncErr
);
  localparam int CNT_W = $clog2(MAX_CH+1);
  localparam int DEP_W = $clog2(SLOT_W+1);
  localparam int BIT_W = $clog2(SLOT_W);
  localparam int CH_W  = $clog2(MAX_CH);
  localparam int POS_W = $clog2(MAX_CH*SLOT_W);
  localparam int LEN_W = POS_W + 1;

  logic bclkPrev, fsPrev, locked, slotGood;
  logic [POS_W-1:0] frameCnt;

  logic rise, syncEdge, active, realign, goodNext, inWindow, lastBit;
  logic [CNT_W-1:0] chanEff;
  logic [LEN_W-1:0] frameLen, offExt, dataPosW;
  logic [POS_W-1:0] cntInc, curPos, dataPos;
  logic [BIT_W-1:0] bitIdx;

  always_comb begin
    rise     = bclkS & ~bclkPrev;
    syncEdge = rise & (cfgSyncFall ? (fsPrev & ~fsS) : (~fsPrev & fsS));
    active   = rise & (locked | syncEdge);

    if (cfgChanCount == '0)                    chanEff = CNT_W'(1);
    else if (cfgChanCount > CNT_W'(MAX_CH))    chanEff = CNT_W'(MAX_CH);
    else                                       chanEff = cfgChanCount;
    if (cfgBitDepth == '0 || cfgBitDepth > DEP_W'(SLOT_W)) depthEff = DEP_W'(SLOT_W);
    else                                                   depthEff = cfgBitDepth;

    frameLen = LEN_W'(chanEff) * LEN_W'(SLOT_W);
    cntInc   = ({1'b0, frameCnt} == frameLen - LEN_W'(1)) ? '0 : frameCnt + POS_W'(1);
    curPos   = syncEdge ? '0 : cntInc;

    // data position trails the frame position by the offset, wrapping at the frame end
    offExt   = LEN_W'(cfgOffset);
    if ({1'b0, curPos} >= offExt) dataPosW = {1'b0, curPos} - offExt;
    else                          dataPosW = {1'b0, curPos} + frameLen - offExt;
    dataPos  = dataPosW[POS_W-1:0];
    slotIdx  = CH_W'(dataPos >> BIT_W);
    bitIdx   = dataPos[BIT_W-1:0];
    lastBit  = (bitIdx == BIT_W'(SLOT_W-1));

    inWindow = cfgRightJust ? (DEP_W'(bitIdx) >= DEP_W'(SLOT_W) - depthEff)
                            : (DEP_W'(bitIdx) < depthEff);

    realign  = syncEdge & (~locked | (cntInc != '0));
    if (bitIdx == '0)  goodNext = 1'b1;
    else if (realign)  goodNext = 1'b0;
    else               goodNext = slotGood;

    strobe.shift = active & inWindow;
    strobe.emit  = active & lastBit & goodNext;
    strobe.sdBit = sdS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      fsPrev   <= 1'b0;
      locked   <= 1'b0;
      slotGood <= 1'b0;
      frameCnt <= '0;
      syncErr  <= 1'b0;
    end else begin
      bclkPrev <= bclkS;
      syncErr  <= 1'b0;
      if (rise) fsPrev <= fsS;
      if (active) begin
        frameCnt <= curPos;
        locked   <= 1'b1;
        slotGood <= goodNext;
        syncErr  <= syncEdge & locked & (cntInc != '0);
      end
    end
  end

  // R9: a sync error coincides with the counter restarting at the edge bit
  assert_err_realign_R9: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |-> (frameCnt == '0));
  // R9: the error flag is a single-cycle pulse
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> !syncErr);
  // R4: an emitted channel index stays below the configured count
  assert_chan_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> (CNT_W'(slotIdx) < chanEff));
  // R10: sync history advances only on rising bit clock edges
  assert_sync_on_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(bclkS & ~bclkPrev) |=> $stable(fsPrev));
endmodule

// File: rtl/pcm_rx_dp.sv
module pcm_rx_dp
  import pcm_rx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int MAX_CH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rxStrobe_t                   strobe,
  input  logic [$clog2(MAX_CH)-1:0]   slotIdx,
  input  logic [$clog2(SLOT_W+1)-1:0] depthEff,
  input  logic                        cfgLsbFirst,
  output logic [SLOT_W-1:0]           sampleData,
  output logic [$clog2(MAX_CH)-1:0]   sampleChan,
  output logic                        sampleValid
);
  localparam int DEP_W = $clog2(SLOT_W+1);

  logic [SLOT_W-1:0] shReg, nextSh, aligned, result;
  logic [DEP_W-1:0]  shAmt;

  always_comb begin
    shAmt = DEP_W'(SLOT_W) - depthEff;
    if (!strobe.shift)    nextSh = shReg;
    else if (cfgLsbFirst) nextSh = {strobe.sdBit, shReg[SLOT_W-1:1]};
    else                  nextSh = {shReg[SLOT_W-2:0], strobe.sdBit};
    // bring the sample MSB to the top, then arithmetic shift back down
    aligned = cfgLsbFirst ? nextSh : (nextSh << shAmt);
    result  = SLOT_W'($signed(aligned) >>> shAmt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg       <= '0;
      sampleData  <= '0;
      sampleChan  <= '0;
      sampleValid <= 1'b0;
    end else begin
      shReg       <= nextSh;
      sampleValid <= strobe.emit;
      if (strobe.emit) begin
        sampleData <= result;
        sampleChan <= slotIdx;
      end
    end
  end

  // R7: valid lasts one system clock
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);
  // R7: output sample holds between strobes
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(sampleData));
endmodule

// File: rtl/pcm_tdm_rx.sv
module pcm_tdm_rx
  import pcm_rx_pkg::*;
#(
  parameter int SLOT_W      = 32,
  parameter int MAX_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          bclkIn,
  input  logic                          fsyncIn,
  input  logic                          sdIn,
  input  logic                          cfgSyncFall,
  input  logic [$clog2(MAX_CH+1)-1:0]   cfgChanCount,
  input  logic [$clog2(SLOT_W+1)-1:0]   cfgBitDepth,
  input  logic [$clog2(SLOT_W)-1:0]     cfgOffset,
  input  logic                          cfgRightJust,
  input  logic                          cfgLsbFirst,
  output logic [SLOT_W-1:0]             sampleData,
  output logic [$clog2(MAX_CH)-1:0]     sampleChan,
  output logic                          sampleValid,
  output logic                          syncErr
);
  localparam int DEP_W = $clog2(SLOT_W+1);
  localparam int CH_W  = $clog2(MAX_CH);

  logic [2:0]       syncOut;
  rxStrobe_t        strobe;
  logic [CH_W-1:0]  slotIdx;
  logic [DEP_W-1:0] depthEff;

  pcm_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .din({bclkIn, fsyncIn, sdIn}), .dout(syncOut)
  );

  pcm_rx_ctrl #(.SLOT_W(SLOT_W), .MAX_CH(MAX_CH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .bclkS(syncOut[2]), .fsS(syncOut[1]), .sdS(syncOut[0]),
    .cfgSyncFall(cfgSyncFall), .cfgChanCount(cfgChanCount),
    .cfgBitDepth(cfgBitDepth), .cfgOffset(cfgOffset),
    .cfgRightJust(cfgRightJust),
    .strobe(strobe), .slotIdx(slotIdx), .depthEff(depthEff), .syncErr(syncErr)
  );

  pcm_rx_dp #(.SLOT_W(SLOT_W), .MAX_CH(MAX_CH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .depthEff(depthEff), .cfgLsbFirst(cfgLsbFirst),
    .sampleData(sampleData), .sampleChan(sampleChan), .sampleValid(sampleValid)
  );
endmodule

// File: tb/tb_pcm_tdm_rx.sv
module tb_pcm_tdm_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclkIn = 1'b0, fsyncIn = 1'b0, sdIn = 1'b0;
  logic cSyncFall = 1'b0, cRight = 1'b0, cLsb = 1'b0;
  int   cChans = 2, cDepth = 24, cOffset = 0;
  logic [3:0] cfgChanCount;
  logic [5:0] cfgBitDepth;
  logic [4:0] cfgOffset;
  logic [31:0] sampleData;
  logic [2:0]  sampleChan;
  logic        sampleValid, syncErr;

  int checks = 0, failures = 0;
  int gotN = 0, errCount = 0, longPulse = 0;
  logic prevValid = 1'b0;
  logic [31:0] gotData [64];
  logic [2:0]  gotChan [64];
  bit done = 0;

  assign cfgChanCount = 4'(cChans);
  assign cfgBitDepth  = 6'(cDepth);
  assign cfgOffset    = 5'(cOffset);

  always #2 clk = ~clk;  // 250 MHz

  pcm_tdm_rx dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .fsyncIn(fsyncIn), .sdIn(sdIn),
    .cfgSyncFall(cSyncFall), .cfgChanCount(cfgChanCount), .cfgBitDepth(cfgBitDepth),
    .cfgOffset(cfgOffset), .cfgRightJust(cRight), .cfgLsbFirst(cLsb),
    .sampleData(sampleData), .sampleChan(sampleChan), .sampleValid(sampleValid),
    .syncErr(syncErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        if (gotN < 64) begin
          gotData[gotN] = sampleData;
          gotChan[gotN] = sampleChan;
        end
        gotN++;
        if (prevValid) longPulse++;
      end
      if (syncErr) errCount++;
    end
    prevValid = sampleValid;
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int f, int ch);
    return 32'h8D3C_5A17 ^ (32'(f) * 32'h0123_4F6B) ^ (32'(ch) * 32'h2B1D_7C39);
  endfunction

  function automatic logic [31:0] expVal(int f, int ch);
    logic [31:0] v = pat(f, ch);
    int sh = 32 - cDepth;
    return 32'($signed(v << sh) >>> sh);
  endfunction

  function automatic logic sdFor(int f, int d);
    int slot = d / 32, b = d % 32, k;
    logic [31:0] v;
    if (f < 0) return 1'b1;
    v = pat(f, slot);
    if (cRight) begin
      if (b < 32 - cDepth) return 1'b1;
      k = b - (32 - cDepth);
    end else begin
      if (b >= cDepth) return 1'b1;
      k = b;
    end
    return cLsb ? v[k] : v[cDepth-1-k];
  endfunction

  task automatic bitClk(logic fs, logic sd);
    @(negedge clk);
    bclkIn = 1'b0; fsyncIn = fs; sdIn = sd;
    repeat (4) @(negedge clk);
    bclkIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset(logic fsIdle);
    rstN = 1'b0; bclkIn = 1'b0; fsyncIn = fsIdle; sdIn = 1'b1;
    repeat (5) @(negedge clk);
    gotN = 0; errCount = 0; longPulse = 0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic dataFor(int f, int p, int L, output logic sd);
    if (p >= cOffset) sd = sdFor(f, p - cOffset);
    else              sd = sdFor(f - 1, p - cOffset + L);
  endtask

  task automatic runStream(string req, int nFrames, int cutFrame, int cutLen);
    int L = cChans * 32;
    logic act = cSyncFall ? 1'b0 : 1'b1;
    logic sd;
    int expN = 0;
    doReset(~act);
    for (int i = 0; i < 4; i++) bitClk(~act, 1'b1);
    for (int f = 0; f < nFrames; f++) begin
      int len = (f == cutFrame) ? cutLen : L;
      for (int p = 0; p < len; p++) begin
        dataFor(f, p, L, sd);
        bitClk((p < L/2) ? act : ~act, sd);
      end
    end
    for (int p = 0; p < 6; p++) begin
      dataFor(nFrames, p, L, sd);
      bitClk(~act, sd);
    end
    repeat (12) @(negedge clk);
    for (int f = 0; f < nFrames; f++) begin
      for (int ch = 0; ch < cChans; ch++) begin
        if (f == cutFrame && ch * 32 + 32 > cutLen) continue;
        if (expN < gotN && expN < 64) begin
          check(gotData[expN] == expVal(f, ch), req, $sformatf("data f%0d ch%0d", f, ch),
                gotData[expN], expVal(f, ch));
          check(gotChan[expN] == 3'(ch), req, $sformatf("chan f%0d", f),
                32'(gotChan[expN]), 32'(ch));
        end
        expN++;
      end
    end
    check(gotN == expN, req, "sample count", 32'(gotN), 32'(expN));
    check(longPulse == 0, "R7", "valid longer than one cycle", 32'(longPulse), 0);
    check(errCount == ((cutFrame >= 0) ? 1 : 0), "R9", "sync error pulses",
          32'(errCount), (cutFrame >= 0) ? 32'd1 : 32'd0);
  endtask

  task automatic setCfg(logic fall, int ch, int dep, int off, logic rj, logic lsb);
    cSyncFall = fall; cChans = ch; cDepth = dep; cOffset = off; cRight = rj; cLsb = lsb;
  endtask

  task automatic testReset();  // R1
    setCfg(1'b0, 2, 24, 0, 1'b0, 1'b0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(sampleValid == 1'b0, "R1", "valid in reset", 32'(sampleValid), 0);
    check(syncErr == 1'b0, "R1", "syncErr in reset", 32'(syncErr), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(sampleValid == 1'b0, "R1", "valid after reset", 32'(sampleValid), 0);
    check(syncErr == 1'b0, "R1", "syncErr after reset", 32'(syncErr), 0);
  endtask

  task automatic testStereoOffset();  // R2 R3 R8 R10: falling edge, one-bit offset
    setCfg(1'b1, 2, 24, 1, 1'b0, 1'b0);
    runStream("R2/R3/R8/R10", 3, -1, 0);
  endtask

  task automatic testLeftJust();  // R2 R5: rising edge, no offset
    setCfg(1'b0, 2, 24, 0, 1'b0, 1'b0);
    runStream("R2/R5", 3, -1, 0);
  endtask

  task automatic testRightJust();  // R5
    setCfg(1'b0, 2, 24, 0, 1'b1, 1'b0);
    runStream("R5", 3, -1, 0);
  endtask

  task automatic testTdm4();  // R4
    setCfg(1'b0, 4, 24, 0, 1'b0, 1'b0);
    runStream("R4", 2, -1, 0);
  endtask

  task automatic testTdm6Full();  // R4 R7: full-width slots, falling edge
    setCfg(1'b1, 6, 32, 0, 1'b0, 1'b0);
    runStream("R4/R7", 2, -1, 0);
  endtask

  task automatic testLsbFirst();  // R6 with offset 2
    setCfg(1'b0, 2, 16, 2, 1'b0, 1'b1);
    runStream("R6", 3, -1, 0);
  endtask

  task automatic testShortRight();  // R7 sign extension of 8-bit samples, R3 offset
    setCfg(1'b1, 8, 8, 3, 1'b1, 1'b0);
    runStream("R7/R3", 2, -1, 0);
  endtask

  task automatic testSyncError();  // R9 R8: early edge, partial slot dropped
    setCfg(1'b0, 2, 24, 0, 1'b0, 1'b0);
    runStream("R9/R8", 4, 1, 40);
  endtask

  initial begin
    testReset();
    testStereoOffset();
    testLeftJust();
    testRightJust();
    testTdm4();
    testTdm6Full();
    testLsbFirst();
    testShortRight();
    testSyncError();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule